// File: doc/BRIEF.md
# Sector-Based Bridge Gate Steering

This block sits between a one-cycle pulse-width modulator core and the six gate drivers of a three-phase, six-switch boost rectifier bridge. From the sign bits of the three phase voltages it works out which 60° sector of the line period is in force. The sector is the one phase whose polarity differs from the other two. The two phases that share a polarity own the two switches that are modulated in that sector. Those two switches are always on the same side of the bridge. The other four switches are held off, so their anti-parallel diodes carry the current.

Each rising pulse of the cycle strobe starts a switching cycle. At that point the block latches the sector and turns on both selected switches together. During the cycle, the modulator core raises two turn-off requests. The first request releases the switch that the sector names as leading, and the second releases the trailing one. A released switch stays off until the next cycle start. Sign changes between strobes are not acted on until the next strobe, so the routing can never move in the middle of a cycle. Sign vectors that name no sector shut every gate and raise an error flag.

Top module: `bridge_gate_steer`

## Requirements
- R1: Sign inputs use bit 0 = phase a, bit 1 = phase b, bit 2 = phase c, with 1 meaning positive. At a cycle start the sector output becomes 0 for 101, 1 for 001, 2 for 011, 3 for 010, 4 for 110 and 5 for 100.
- R2: After a cycle start with a legal sign vector, exactly the two gates of the two like-signed phases are on and the other four are off.
- R3: A positive pair drives the lower gates (gate_lo) and a negative pair drives the upper gates (gate_hi). An upper and a lower gate are never on at the same time.
- R4: rel_first turns off the leading phase of the latched sector. The leading phase is the one just before the odd phase in the cyclic order a→b→c→a. Sectors 0..5 lead with a, c, b, a, c, b.
- R5: rel_second turns off the trailing phase, which is the one just after the odd phase. Sectors 0..5 trail with c, b, a, c, b, a. The two requests act independently and may arrive in the same cycle.
- R6: The sector and the gate routing change only on a cycle-start edge. Sign changes between strobes have no effect, and releases use the latched sector.
- R7: A sign vector of 000 or 111 at a cycle start turns all gates off, sets sign_err and reports sector 7. The flag holds until the next cycle start with a legal vector, and release requests do nothing in the meantime.
- R8: Reset sets all gates off, sector 7 and sign_err low. Gates stay off until the next cycle start, whatever the release inputs do.
- R9: A released gate stays off for the rest of the cycle even after its request drops. A cycle start that coincides with a request turns the pair on, and the request is ignored.
- R10: Every output is registered and changes on the first rising clock edge at which the causing input is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Switching-cycle strobe, one clock wide |
| phase_sign | input | 3 | Phase polarity bits {c,b,a}, 1 = positive |
| rel_first | input | 1 | Turn-off request for the leading switch |
| rel_second | input | 1 | Turn-off request for the trailing switch |
| gate_hi | output | 3 | Upper-switch gate enables {c,b,a} |
| gate_lo | output | 3 | Lower-switch gate enables {c,b,a} |
| sector | output | 3 | Latched sector 0..5, 7 when none |
| sign_err | output | 1 | Illegal sign vector latched at the last cycle start |

## Verification
Every output is due exactly one rising edge after the inputs that cause it are sampled. A strobe, a release or a reset applied before edge k is therefore visible just after edge k, and no later edge is needed. The driver changes inputs on the falling edge and pushes the expected gate, sector and flag values for the next rising edge. The monitor pops that entry 1 ns after the rising edge, so each comparison lines up with the one edge that the stimulus can affect.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

    localparam int NUM_PH = 3;
    localparam int PH_W   = 2;
    localparam int SEC_W  = 3;
    localparam logic [SEC_W-1:0] SEC_NONE = 3'd7;

    typedef logic [PH_W-1:0] ph_idx_t;

    typedef struct packed {
        logic              valid;
        logic [SEC_W-1:0]  code;
        logic              upper;
        ph_idx_t           first_ph;
        ph_idx_t           second_ph;
    } route_t;

    localparam route_t ROUTE_IDLE = '{valid: 1'b0, code: SEC_NONE, upper: 1'b0,
                                      first_ph: '0, second_ph: '0};

    function automatic logic [SEC_W-1:0] sector_code(input logic [NUM_PH-1:0] s);
        case (s)
            3'b101:  return 3'd0;
            3'b001:  return 3'd1;
            3'b011:  return 3'd2;
            3'b010:  return 3'd3;
            3'b110:  return 3'd4;
            3'b100:  return 3'd5;
            default: return SEC_NONE;
        endcase
    endfunction

    function automatic route_t decode_signs(input logic [NUM_PH-1:0] s);
        route_t  r;
        logic    maj;
        ph_idx_t odd;
        maj = (s[0] & s[1]) | (s[1] & s[2]) | (s[0] & s[2]);
        if (s[0] != maj)      odd = 2'd0;
        else if (s[1] != maj) odd = 2'd1;
        else                  odd = 2'd2;
        r.valid     = (s != 3'b000) && (s != 3'b111);
        r.code      = sector_code(s);
        r.upper     = ~maj;
        r.first_ph  = (odd == 2'd0) ? 2'd2 : odd - 2'd1;
        r.second_ph = (odd == 2'd2) ? 2'd0 : odd + 2'd1;
        if (!r.valid) r = ROUTE_IDLE;
        return r;
    endfunction

endpackage

// File: rtl/bgs_decode.sv
module bgs_decode
    import bgs_pkg::*;
(
    input  logic [NUM_PH-1:0] sign_in,
    output route_t            route_out
);
    always_comb route_out = decode_signs(sign_in);
endmodule

// File: rtl/bgs_sector_latch.sv
module bgs_sector_latch
    import bgs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cyc_start,
    input  route_t route_in,
    output route_t route_q,
    output logic   err_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= ROUTE_IDLE;
            err_q   <= 1'b0;
        end else if (cyc_start) begin
            route_q <= route_in;
            err_q   <= ~route_in.valid;
        end
    end
endmodule

// File: rtl/bgs_gate_leg.sv
module bgs_gate_leg
    import bgs_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   cyc_start,
    input  route_t route_new,
    input  route_t route_cur,
    input  logic   rel_first,
    input  logic   rel_second,
    output logic   hi_q,
    output logic   lo_q
);
    localparam ph_idx_t MY_PH = ph_idx_t'(IDX);

    logic sel_new;
    logic drop;

    always_comb begin
        sel_new = route_new.valid &&
                  (route_new.first_ph == MY_PH || route_new.second_ph == MY_PH);
        drop    = route_cur.valid &&
                  ((rel_first  && route_cur.first_ph  == MY_PH) ||
                   (rel_second && route_cur.second_ph == MY_PH));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else if (cyc_start) begin
            hi_q <= sel_new & route_new.upper;
            lo_q <= sel_new & ~route_new.upper;
        end else if (drop) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end
    end
endmodule

// File: rtl/bridge_gate_steer.sv
module bridge_gate_steer
    import bgs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_start,
    input  logic [NUM_PH-1:0] phase_sign,
    input  logic              rel_first,
    input  logic              rel_second,
    output logic [NUM_PH-1:0] gate_hi,
    output logic [NUM_PH-1:0] gate_lo,
    output logic [SEC_W-1:0]  sector,
    output logic              sign_err
);
    route_t route_new;
    route_t route_cur;
    logic   err_q;

    bgs_decode dec_i (
        .sign_in   (phase_sign),
        .route_out (route_new)
    );

    bgs_sector_latch lat_i (
        .clk       (clk),
        .rst       (rst),
        .cyc_start (cyc_start),
        .route_in  (route_new),
        .route_q   (route_cur),
        .err_q     (err_q)
    );

    for (genvar p = 0; p < NUM_PH; p++) begin : g_leg
        bgs_gate_leg #(.IDX(p)) leg_i (
            .clk        (clk),
            .rst        (rst),
            .cyc_start  (cyc_start),
            .route_new  (route_new),
            .route_cur  (route_cur),
            .rel_first  (rel_first),
            .rel_second (rel_second),
            .hi_q       (gate_hi[p]),
            .lo_q       (gate_lo[p])
        );
    end

    assign sector   = route_cur.code;
    assign sign_err = err_q;
endmodule

// File: rtl/bgs_checker.sv
module bgs_checker (
    input logic       clk,
    input logic       rst,
    input logic       cyc_start,
    input logic [2:0] gate_hi,
    input logic [2:0] gate_lo,
    input logic [2:0] sector,
    input logic       sign_err
);
    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
        !((|gate_hi) && (|gate_lo))); // R3

    AST_PAIR_LIMIT: assert property (@(posedge clk) disable iff (rst)
        $countones({gate_hi, gate_lo}) <= 2); // R2

    AST_SECTOR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cyc_start |=> $stable(sector)); // R6

    AST_NO_MID_TURN_ON: assert property (@(posedge clk) disable iff (rst)
        !cyc_start |=> (((gate_hi | gate_lo) & ~$past(gate_hi | gate_lo)) == 3'b000)); // R9

    AST_ERR_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
        sign_err |-> (gate_hi == 3'b000 && gate_lo == 3'b000)); // R7

    AST_ERR_SECTOR: assert property (@(posedge clk) disable iff (rst)
        sign_err |-> (sector == 3'd7)); // R7

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (gate_hi == 3'b000 && gate_lo == 3'b000 && sector == 3'd7 && !sign_err)); // R8
endmodule

bind bridge_gate_steer bgs_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .cyc_start (cyc_start),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo),
    .sector    (sector),
    .sign_err  (sign_err)
);

// File: tb/bridge_gate_steer_tb_top.sv
module bridge_gate_steer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_start = 1'b0;
    logic [2:0] phase_sign = 3'b000;
    logic       rel_first = 1'b0;
    logic       rel_second = 1'b0;
    logic [2:0] gate_hi, gate_lo, sector;
    logic       sign_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        logic [2:0] hi;
        logic [2:0] lo;
        logic [2:0] sec;
        logic       err;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    logic [2:0] m_hi = '0, m_lo = '0, m_sec = 3'd7;
    logic       m_err = 1'b0, m_ok = 1'b0;
    int         m_f = 0, m_s = 0;

    always #5 clk = ~clk;

    bridge_gate_steer dut_i (
        .clk        (clk),
        .rst        (rst),
        .cyc_start  (cyc_start),
        .phase_sign (phase_sign),
        .rel_first  (rel_first),
        .rel_second (rel_second),
        .gate_hi    (gate_hi),
        .gate_lo    (gate_lo),
        .sector     (sector),
        .sign_err   (sign_err)
    );

    // Expected sector table written from R1, R3, R4, R5
    task automatic bench_table(input logic [2:0] s, output logic ok, output logic [2:0] sec,
                               output logic up, output int f, output int sc);
        ok = 1'b1;
        case (s)
            3'b101: begin sec = 3'd0; up = 1'b0; f = 0; sc = 2; end
            3'b001: begin sec = 3'd1; up = 1'b1; f = 2; sc = 1; end
            3'b011: begin sec = 3'd2; up = 1'b0; f = 1; sc = 0; end
            3'b010: begin sec = 3'd3; up = 1'b1; f = 0; sc = 2; end
            3'b110: begin sec = 3'd4; up = 1'b0; f = 2; sc = 1; end
            3'b100: begin sec = 3'd5; up = 1'b1; f = 1; sc = 0; end
            default: begin ok = 1'b0; sec = 3'd7; up = 1'b0; f = 0; sc = 0; end
        endcase
    endtask

    task automatic step(input logic r, input logic cs, input logic [2:0] sg,
                        input logic rf, input logic rs, input string tag);
        logic ok, up;
        logic [2:0] sec, mask;
        int f, sc;
        exp_t e;
        @(negedge clk);
        rst = r; cyc_start = cs; phase_sign = sg; rel_first = rf; rel_second = rs;
        if (r) begin
            m_hi = '0; m_lo = '0; m_sec = 3'd7; m_err = 1'b0; m_ok = 1'b0;
        end else if (cs) begin
            bench_table(sg, ok, sec, up, f, sc);
            m_ok = ok;
            if (ok) begin
                mask = 3'(1 << f) | 3'(1 << sc);
                m_hi = up ? mask : 3'b000;
                m_lo = up ? 3'b000 : mask;
                m_sec = sec; m_err = 1'b0; m_f = f; m_s = sc;
            end else begin
                m_hi = '0; m_lo = '0; m_sec = 3'd7; m_err = 1'b1;
            end
        end else if (m_ok) begin
            if (rf) begin m_hi[m_f] = 1'b0; m_lo[m_f] = 1'b0; end
            if (rs) begin m_hi[m_s] = 1'b0; m_lo[m_s] = 1'b0; end
        end
        e.hi = m_hi; e.lo = m_lo; e.sec = m_sec; e.err = m_err; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares 1 ns after each rising edge (R10 latency)
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                checks++;
                if (gate_hi !== e.hi || gate_lo !== e.lo || sector !== e.sec || sign_err !== e.err) begin
                    failures++;
                    $display("FAIL %s: got hi=%b lo=%b sec=%0d err=%b, want hi=%b lo=%b sec=%0d err=%b",
                             e.tag, gate_hi, gate_lo, sector, sign_err, e.hi, e.lo, e.sec, e.err);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got hung, want completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [2:0] legal [6];
        legal[0] = 3'b101; legal[1] = 3'b001; legal[2] = 3'b011;
        legal[3] = 3'b010; legal[4] = 3'b110; legal[5] = 3'b100;

        // R8 reset state and no turn-on before a strobe
        repeat (3) step(1, 0, 3'b101, 0, 0, "R8 reset");
        step(0, 0, 3'b101, 1, 1, "R8 idle after reset");
        step(0, 0, 3'b011, 0, 0, "R8 idle after reset");

        // R1, R2, R3, R4, R5, R9 for every sector
        for (int k = 0; k < 6; k++) begin
            step(0, 1, legal[k], 0, 0, "R1 R2 R3 cycle start");
            step(0, 0, legal[k], 0, 0, "R2 hold");
            step(0, 0, legal[k], 1, 0, "R4 leading release");
            step(0, 0, legal[k], 0, 0, "R9 stays off");
            step(0, 0, legal[k], 0, 1, "R5 trailing release");
            step(0, 0, legal[k], 0, 0, "R9 all off");
        end

        // R5: trailing before leading, then both at once
        step(0, 1, 3'b110, 0, 0, "R1 sector 4");
        step(0, 0, 3'b110, 0, 1, "R5 trailing alone");
        step(0, 0, 3'b110, 1, 0, "R4 leading after");
        step(0, 1, 3'b001, 0, 0, "R1 sector 1");
        step(0, 0, 3'b001, 1, 1, "R5 both together");

        // R6: sign change mid-cycle ignored
        step(0, 1, 3'b101, 0, 0, "R6 start sector 0");
        step(0, 0, 3'b010, 0, 0, "R6 mid-cycle sign change");
        step(0, 0, 3'b010, 1, 0, "R6 release uses latched sector");
        step(0, 1, 3'b010, 0, 0, "R6 new sector at strobe");

        // R7 illegal vectors
        step(0, 1, 3'b000, 0, 0, "R7 illegal 000");
        step(0, 0, 3'b000, 1, 1, "R7 release ignored");
        step(0, 1, 3'b111, 0, 0, "R7 illegal 111");
        step(0, 0, 3'b101, 0, 0, "R7 flag held");
        step(0, 1, 3'b011, 0, 0, "R7 cleared by legal start");

        // R9 strobe coinciding with requests
        step(0, 1, 3'b100, 1, 1, "R9 start wins");
        step(0, 0, 3'b100, 0, 0, "R9 pair still on");

        // R8 reset mid-run
        step(1, 0, 3'b100, 0, 0, "R8 reset mid-run");
        step(0, 0, 3'b100, 1, 0, "R8 off until strobe");
        step(0, 1, 3'b100, 0, 0, "R1 after reset");

        step(0, 0, 3'b100, 0, 0, "R10 drain");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule